// File: doc/BRIEF.md
# Per-core Interrupt CPU Interface

This block sits between an interrupt distributor and one processor core. The distributor presents its best pending candidate, an ID and a priority, together with a valid flag. The block decides whether that candidate may interrupt the core, drives a single request line, and keeps track of the one interrupt the core is currently handling.

The core sees four registers on a simple request/response bus. The bus has a request strobe, a write flag, a byte address and write data. Read data comes back registered one cycle later. The four registers are an enable, a priority threshold, an acknowledge register that is read to claim the interrupt, and an end-of-interrupt register that is written to release it. Each claim and each release is reported to the distributor as a one-cycle pulse that carries the ID, so the distributor can mark the interrupt active or clear its active state.

Top module: `irq_cpu_port`

## Requirements
- R1: After reset the enable reads 0, the threshold reads 0, the request line is low, and neither pulse output is asserted.
- R2: While the enable (bit 0 at byte offset 0x0) is 0, the request line stays low whatever the candidate is.
- R3: The request line is high exactly when all of the following hold: the block is enabled, the candidate is valid, the candidate priority is numerically lower than the threshold (offset 0x4, low PRIO_W bits), and no interrupt is in service. A lower number means more urgent.
- R4: A read of offset 0x8 while the request line is high returns the candidate ID, zero-extended to the data width. One cycle later the block raises `ack_pulse` for one cycle with that ID on `ack_id`.
- R5: A read of offset 0x8 while the request line is low returns 1023 and raises no acknowledge pulse. It also changes no internal state.
- R6: After a successful acknowledge, the request line is low from the next cycle on. It stays low until a matching end-of-interrupt write, even if another candidate qualifies.
- R7: A write to offset 0xC whose data equals the ID in service raises `eoi_pulse` for one cycle with that ID and ends service. From then on the request line follows R3 again.
- R8: A write to offset 0xC whose data differs from the ID in service, or that arrives when nothing is in service, is ignored: there is no pulse and service does not change.
- R9: Every read returns its data on `rsp_rdata`, with `rsp_valid` high, one cycle after the request. The enable and threshold read back zero-extended to the data width.
- R10: A read of offset 0x8 while an interrupt is in service returns 1023.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cand_valid | input | 1 | The distributor has a pending candidate |
| cand_id | input | ID_W | ID of the candidate, never 1023 |
| cand_prio | input | PRIO_W | Priority of the candidate, lower is more urgent |
| req_valid | input | 1 | Register access strobe |
| req_write | input | 1 | 1 for a write, 0 for a read |
| req_addr | input | ADDR_W | Byte offset of the register |
| req_wdata | input | DATA_W | Write data |
| rsp_valid | output | 1 | Read data is valid |
| rsp_rdata | output | DATA_W | Read data |
| irq_out | output | 1 | Interrupt request to the core |
| ack_pulse | output | 1 | The candidate was claimed |
| ack_id | output | ID_W | ID that was claimed |
| eoi_pulse | output | 1 | Handling of an ID has ended |
| eoi_id | output | ID_W | ID whose handling has ended |

## Verification
The assertions check four things on every cycle. The request line is silent while the block is disabled or an interrupt is in service. An acknowledge pulse happens only when nothing is in service and never carries the reserved ID. An end-of-interrupt pulse always names the ID that was in service. A read response always follows a read request. Some behaviour only the bench scenarios can show. These are the exact qualifying rule over every threshold and priority pair, the value returned for claimed and spurious reads, and that a mismatched release or a spurious read leaves the service state untouched.

// File: rtl/irq_cpu_port.sv
module irq_cpu_port #(
  parameter int ID_W   = 10,
  parameter int PRIO_W = 8,
  parameter int ADDR_W = 4,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cand_valid,
  input  logic [ID_W-1:0]   cand_id,
  input  logic [PRIO_W-1:0] cand_prio,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              irq_out,
  output logic              ack_pulse,
  output logic [ID_W-1:0]   ack_id,
  output logic              eoi_pulse,
  output logic [ID_W-1:0]   eoi_id
);
  localparam logic [ID_W-1:0]   SPURIOUS = ID_W'(1023);
  localparam logic [ADDR_W-1:0] OFF_CTRL = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] OFF_MASK = ADDR_W'(4);
  localparam logic [ADDR_W-1:0] OFF_ACK  = ADDR_W'(8);
  localparam logic [ADDR_W-1:0] OFF_EOI  = ADDR_W'(12);

  logic              en_q;
  logic [PRIO_W-1:0] pmask_q;
  logic              svc_q;
  logic [ID_W-1:0]   svc_id_q;
  logic [DATA_W-1:0] rd_mux;

  wire rd       = req_valid && !req_write;
  wire wr       = req_valid && req_write;
  wire eligible = en_q && cand_valid && (cand_prio < pmask_q) && !svc_q;
  wire take     = rd && (req_addr == OFF_ACK) && eligible;
  wire eoi_hit  = wr && (req_addr == OFF_EOI) && svc_q &&
                  (req_wdata == DATA_W'(svc_id_q));

  assign irq_out = eligible;

  always_comb begin
    case (req_addr)
      OFF_CTRL: rd_mux = DATA_W'(en_q);
      OFF_MASK: rd_mux = DATA_W'(pmask_q);
      OFF_ACK:  rd_mux = take ? DATA_W'(cand_id) : DATA_W'(SPURIOUS);
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q      <= 1'b0;
      pmask_q   <= '0;
      svc_q     <= 1'b0;
      svc_id_q  <= '0;
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
      ack_pulse <= 1'b0;
      ack_id    <= '0;
      eoi_pulse <= 1'b0;
      eoi_id    <= '0;
    end else begin
      rsp_valid <= rd;
      rsp_rdata <= rd ? rd_mux : '0;
      ack_pulse <= take;
      eoi_pulse <= eoi_hit;
      if (take) ack_id <= cand_id;
      if (eoi_hit) eoi_id <= svc_id_q;
      if (wr && req_addr == OFF_CTRL) en_q <= req_wdata[0];
      if (wr && req_addr == OFF_MASK) pmask_q <= req_wdata[PRIO_W-1:0];
      if (take) begin
        svc_q    <= 1'b1;
        svc_id_q <= cand_id;
      end else if (eoi_hit) begin
        svc_q <= 1'b0;
      end
    end
  end
endmodule

module irq_cpu_port_chk #(
  parameter int ID_W = 10
) (
  input logic            clk,
  input logic            rst_n,
  input logic            req_valid,
  input logic            req_write,
  input logic            rsp_valid,
  input logic            irq_out,
  input logic            ack_pulse,
  input logic [ID_W-1:0] ack_id,
  input logic            eoi_pulse,
  input logic [ID_W-1:0] eoi_id,
  input logic            en_q,
  input logic            svc_q,
  input logic [ID_W-1:0] svc_id_q
);
  AST_QUIET_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !en_q |-> !irq_out); // R2
  AST_LINE_LOW_IN_SERVICE: assert property (@(posedge clk) disable iff (!rst_n)
    svc_q |-> !irq_out); // R6
  AST_ACK_NOT_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
    ack_pulse |-> ack_id != ID_W'(1023)); // R5
  AST_ACK_FROM_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    ack_pulse |-> (!$past(svc_q) && svc_q && svc_id_q == ack_id)); // R6
  AST_EOI_NAMES_SERVICE: assert property (@(posedge clk) disable iff (!rst_n)
    eoi_pulse |-> ($past(svc_q) && !svc_q && eoi_id == $past(svc_id_q))); // R7
  AST_RSP_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_write) |=> rsp_valid); // R9
endmodule

bind irq_cpu_port irq_cpu_port_chk #(.ID_W(ID_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
  .rsp_valid(rsp_valid), .irq_out(irq_out), .ack_pulse(ack_pulse),
  .ack_id(ack_id), .eoi_pulse(eoi_pulse), .eoi_id(eoi_id),
  .en_q(en_q), .svc_q(svc_q), .svc_id_q(svc_id_q)
);

// File: tb/test_irq_cpu_port.sv
module test_irq_cpu_port;
  localparam int ID_W = 10, PRIO_W = 3, ADDR_W = 4, DATA_W = 32;

  logic clk = 0, rst_n = 0;
  logic cand_valid = 0;
  logic [ID_W-1:0] cand_id = '0;
  logic [PRIO_W-1:0] cand_prio = '0;
  logic req_valid = 0, req_write = 0;
  logic [ADDR_W-1:0] req_addr = '0;
  logic [DATA_W-1:0] req_wdata = '0;
  logic rsp_valid, irq_out, ack_pulse, eoi_pulse;
  logic [DATA_W-1:0] rsp_rdata;
  logic [ID_W-1:0] ack_id, eoi_id;

  int checks = 0, failures = 0;
  bit done = 0;
  logic seen_pulse;
  logic [ID_W-1:0] seen_id;
  logic [DATA_W-1:0] rdat;

  always #10 clk = ~clk;

  irq_cpu_port #(.ID_W(ID_W), .PRIO_W(PRIO_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_irq_cpu_port (
    .clk(clk), .rst_n(rst_n), .cand_valid(cand_valid), .cand_id(cand_id),
    .cand_prio(cand_prio), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .rsp_valid(rsp_valid),
    .rsp_rdata(rsp_rdata), .irq_out(irq_out), .ack_pulse(ack_pulse),
    .ack_id(ack_id), .eoi_pulse(eoi_pulse), .eoi_id(eoi_id));

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic rd(input int addr);
    @(negedge clk);
    req_valid = 1; req_write = 0; req_addr = ADDR_W'(addr);
    @(negedge clk);
    req_valid = 0;
    rdat = rsp_valid ? rsp_rdata : 32'hDEAD_BEEF;
    seen_pulse = ack_pulse; seen_id = ack_id;
  endtask

  task automatic wr(input int addr, input int data);
    @(negedge clk);
    req_valid = 1; req_write = 1; req_addr = ADDR_W'(addr); req_wdata = DATA_W'(data);
    @(negedge clk);
    req_valid = 0; req_write = 0;
    seen_pulse = eoi_pulse; seen_id = eoi_id;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++; checks++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(irq_out == 0, "R1 irq after reset", irq_out, 0);
    chk(ack_pulse == 0 && eoi_pulse == 0, "R1 pulses after reset", ack_pulse | eoi_pulse, 0);
    rd(0); chk(rdat == 0, "R1 enable reset", rdat, 0);
    rd(4); chk(rdat == 0, "R1 mask reset", rdat, 0);

    for (int en = 0; en < 2; en++)
      for (int pm = 0; pm < 8; pm++) begin
        wr(0, en); wr(4, pm | 32'hF0);
        rd(4); chk(rdat == 32'(pm), "R9 mask readback", rdat, pm);
        rd(0); chk(rdat == 32'(en), "R9 enable readback", rdat, en);
        for (int v = 0; v < 2; v++)
          for (int pr = 0; pr < 8; pr++) begin
            @(negedge clk);
            cand_valid = v[0]; cand_prio = PRIO_W'(pr); cand_id = ID_W'(pr + 8 * pm);
            #1;
            if (en == 0) chk(irq_out == 0, "R2 disabled line", irq_out, 0);
            else chk(irq_out == (v == 1 && pr < pm), "R3 qualify", irq_out, (v == 1 && pr < pm));
          end
      end

    wr(0, 1); wr(4, 5);
    @(negedge clk); cand_valid = 1; cand_prio = 2; cand_id = 37;
    #1 chk(irq_out == 1, "R3 line up", irq_out, 1);
    rd(8);
    chk(rdat == 37, "R4 ack id", rdat, 37);
    chk(seen_pulse == 1 && seen_id == 37, "R4 ack pulse", seen_id, 37);
    chk(irq_out == 0, "R6 line drops", irq_out, 0);
    @(negedge clk); cand_id = 40; cand_prio = 0;
    repeat (4) @(negedge clk);
    chk(irq_out == 0, "R6 line held low", irq_out, 0);
    rd(8);
    chk(rdat == 1023, "R10 spurious in service", rdat, 1023);
    chk(seen_pulse == 0, "R10 no ack pulse", seen_pulse, 0);
    wr(12, 38);
    chk(seen_pulse == 0, "R8 mismatched eoi", seen_pulse, 0);
    chk(irq_out == 0, "R8 still in service", irq_out, 0);
    wr(12, 37);
    chk(seen_pulse == 1 && seen_id == 37, "R7 eoi pulse", seen_id, 37);
    chk(irq_out == 1, "R7 line back", irq_out, 1);

    wr(12, 40);
    chk(seen_pulse == 0, "R8 eoi with nothing in service", seen_pulse, 0);
    chk(irq_out == 1, "R8 state kept", irq_out, 1);

    @(negedge clk); cand_valid = 0;
    rd(8);
    chk(rdat == 1023, "R5 spurious no candidate", rdat, 1023);
    chk(seen_pulse == 0, "R5 no ack pulse", seen_pulse, 0);
    @(negedge clk); cand_valid = 1; cand_prio = 5;
    rd(8);
    chk(rdat == 1023, "R5 spurious masked", rdat, 1023);
    @(negedge clk); cand_prio = 1; cand_id = 1022;
    #1 chk(irq_out == 1, "R5 no state change", irq_out, 1);
    rd(8);
    chk(rdat == 32'd1022, "R4 max id zero-extended", rdat, 1022);
    chk(seen_pulse == 1 && seen_id == 1022, "R4 ack max id", seen_id, 1022);
    wr(12, 1022);
    chk(seen_pulse == 1 && seen_id == 1022, "R7 eoi max id", seen_id, 1022);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule